// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Service

This block is a windowed watchdog for a processor subsystem. Software programs a reload value and arms the timer with a 32-bit magic word. From then on, a down-counter runs on every cycle in which the count-enable input is high. Software must service the timer before the counter runs out, and only while the counter sits inside an open window at the tail of the period.

A service is an ordered pair of writes to the key register. If the pair completes while the counter is still above the window, that is a fault, just as running out is. A fault sets a sticky status flag. Depending on the expiry-action setting, the flag drives a level interrupt request or a level reset request. Once armed, the timer cannot be stopped by any register write. Only the hardware reset disarms it.

Registers sit on a plain 32-bit write/read bus. Reads are combinational and have no side effects.

Top module: `wwdt_core`

## Requirements
- R1: The timer arms only when exactly 0xA98559DA is written to the control register at offset 0x00. Control reads 0xA98559DA while armed and 0 while disarmed.
- R2: Once armed, no register write disarms the timer. Only rst_n low clears the armed state.
- R3: The reload register at offset 0x04 keeps bits [PRELOAD_W-1:0] of the write data and resets to all ones. The full period is the reload value shifted left by PRE_SHIFT. While disarmed, the counter readback at offset 0x10 shows the full period.
- R4: While armed, each cycle with tick_en high lowers the counter by one. A tick that finds the counter at zero records a fault and reloads the full period. With tick_en low, the counter holds.
- R5: A service is a write of 0xE51A to the key register at offset 0x0C, followed by a write of 0xA35C. If the second write lands while the counter is at or below the full period shifted right by the window index, the counter reloads with no fault. The key register reads 0.
- R6: A service completed while the counter is above the window limit records a fault and still reloads the counter.
- R7: A key write of any value other than the expected next one returns the sequence to idle without a reload. A lone 0xA35C with no 0xE51A before it changes nothing.
- R8: The window register at offset 0x18 accepts 0x50, 0x500, 0x5000, 0x50000 and 0x500000. These select window index 1 to 5, i.e. a window of 1/2 down to 1/32 of the period. It resets to 0x50, reads back the accepted code, and ignores any other value.
- R9: The action register at offset 0x14 accepts 0xA (interrupt on fault) and 0x5 (reset on fault, the reset value). It reads back the accepted code and ignores any other value.
- R10: Status at offset 0x08 shows the fault flag in bit 1. Writing 1 to bit 1 clears it, but a fault in the same cycle wins. While the flag is set, the counter readback returns 0.
- R11: irq_o is high exactly while the fault flag is set in interrupt mode. rst_req_o is high exactly while the fault flag is set in reset mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_en | input | 1 | Count enable for the down-counter |
| irq_o | output | 1 | Level interrupt request on fault |
| rst_req_o | output | 1 | Level reset request on fault |

## Verification
The bench builds the block with PRE_SHIFT set to 2, keeping PRELOAD_W at 12 and ADDR_W at 8. A reload value of 10 then gives a 40-tick period, so expiry, the window edge and every window index can be reached within a few hundred cycles. It covers an early service, an in-window service, an interrupted key sequence, a clear that collides with a fault, and expiry in both action modes, each with its exact cycle.

// File: rtl/wwdt_core.sv
module wwdt_core #(
  parameter int PRELOAD_W = 12,
  parameter int PRE_SHIFT = 13,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic              tick_en,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int CNT_W = PRELOAD_W + PRE_SHIFT;
  localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] ADR_PRE  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] ADR_KEY  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] ADR_CNT  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] ADR_ACT  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] ADR_WIN  = ADDR_W'('h18);
  localparam logic [31:0] RUN_WORD = 32'hA98559DA;
  localparam logic [31:0] KEY_OPEN = 32'h0000E51A;
  localparam logic [31:0] KEY_DONE = 32'h0000A35C;
  localparam logic [31:0] ACT_IRQ  = 32'h0000000A;
  localparam logic [31:0] ACT_RST  = 32'h00000005;

  logic                 run_q, viol_q, nmi_q, svc_q;
  logic [2:0]           win_q;
  logic [PRELOAD_W-1:0] pre_q;
  logic [CNT_W-1:0]     cnt_q;

  logic [CNT_W-1:0] full, win_lim;
  logic wr_ctrl, wr_pre, wr_stat, wr_key, wr_act, wr_win;
  logic serviced, expire, early, set_viol;
  logic       win_ok;
  logic [2:0] win_idx;

  assign wr_ctrl = bus_we && bus_addr == ADR_CTRL;
  assign wr_pre  = bus_we && bus_addr == ADR_PRE;
  assign wr_stat = bus_we && bus_addr == ADR_STAT;
  assign wr_key  = bus_we && bus_addr == ADR_KEY;
  assign wr_act  = bus_we && bus_addr == ADR_ACT;
  assign wr_win  = bus_we && bus_addr == ADR_WIN;

  assign full     = {pre_q, {PRE_SHIFT{1'b0}}};
  assign win_lim  = full >> win_q;
  assign serviced = wr_key && bus_wdata == KEY_DONE && svc_q && run_q;
  assign expire   = run_q && tick_en && cnt_q == '0;
  assign early    = serviced && (cnt_q > win_lim);
  assign set_viol = expire || early;

  always_comb begin
    win_ok  = 1'b0;
    win_idx = 3'd1;
    for (int k = 1; k <= 5; k++) begin
      if (bus_wdata == (32'h5 << (4 * k))) begin
        win_ok  = 1'b1;
        win_idx = 3'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      viol_q <= 1'b0;
      nmi_q  <= 1'b0;
      svc_q  <= 1'b0;
      win_q  <= 3'd1;
      pre_q  <= '1;
      cnt_q  <= '0;
    end else begin
      if (wr_ctrl && bus_wdata == RUN_WORD) run_q <= 1'b1;
      if (wr_pre) pre_q <= bus_wdata[PRELOAD_W-1:0];
      if (!run_q || expire || serviced) cnt_q <= full;
      else if (tick_en) cnt_q <= cnt_q - 1'b1;
      if (wr_key) svc_q <= (bus_wdata == KEY_OPEN);
      if (set_viol) viol_q <= 1'b1;
      else if (wr_stat && bus_wdata[1]) viol_q <= 1'b0;
      if (wr_act && bus_wdata == ACT_IRQ) nmi_q <= 1'b1;
      else if (wr_act && bus_wdata == ACT_RST) nmi_q <= 1'b0;
      if (wr_win && win_ok) win_q <= win_idx;
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_CTRL: bus_rdata = run_q ? RUN_WORD : 32'h0;
      ADR_PRE:  bus_rdata = 32'(pre_q);
      ADR_STAT: bus_rdata = {30'h0, viol_q, 1'b0};
      ADR_CNT:  bus_rdata = viol_q ? 32'h0 : 32'(cnt_q);
      ADR_ACT:  bus_rdata = nmi_q ? ACT_IRQ : ACT_RST;
      ADR_WIN:  bus_rdata = 32'h5 << (4 * win_q);
      default:  bus_rdata = 32'h0;
    endcase
  end

  assign irq_o     = viol_q && nmi_q;
  assign rst_req_o = viol_q && !nmi_q;
endmodule

// File: rtl/wwdt_core_sva.sv
module wwdt_core_sva #(
  parameter int PRELOAD_W = 12,
  parameter int PRE_SHIFT = 13,
  parameter int ADDR_W    = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [31:0]                   bus_wdata,
  input logic                          bus_we,
  input logic                          tick_en,
  input logic                          irq_o,
  input logic                          rst_req_o,
  input logic                          run_q,
  input logic                          viol_q,
  input logic                          svc_q,
  input logic [PRELOAD_W+PRE_SHIFT-1:0] cnt_q
);
  localparam logic [ADDR_W-1:0] ADR_KEY = ADDR_W'('h0C);

  a_r2_stays_armed: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);

  a_r4_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_en && !bus_we && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r4_zero_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_en && cnt_q == '0) |=> viol_q);

  a_r7_lone_second_key: assert property (@(posedge clk) disable iff (!rst_n)
    (!svc_q && bus_we && bus_addr == ADR_KEY && bus_wdata == 32'h0000A35C &&
     !(run_q && tick_en && cnt_q == '0)) |=> $stable(viol_q));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && rst_req_o));

  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_q |-> (!irq_o && !rst_req_o));
endmodule

bind wwdt_core wwdt_core_sva #(.PRELOAD_W(PRELOAD_W), .PRE_SHIFT(PRE_SHIFT), .ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
  .tick_en(tick_en), .irq_o(irq_o), .rst_req_o(rst_req_o), .run_q(run_q),
  .viol_q(viol_q), .svc_q(svc_q), .cnt_q(cnt_q)
);

// File: tb/sim_wwdt_core.sv
module sim_wwdt_core;
  localparam int PW = 12;
  localparam int S  = 2;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_rdata;
  logic          tick_en = 1'b0;
  logic          irq_o, rst_req_o;

  wwdt_core #(.PRELOAD_W(PW), .PRE_SHIFT(S), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .tick_en(tick_en),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always #5 clk = ~clk;

  int    vectors = 0;
  int    misses  = 0;
  string cur_tag = "R3";

  int m_run, m_pre, m_cnt, m_viol, m_nmi, m_k, m_svc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_pre = 4095; m_cnt = 0; m_viol = 0; m_nmi = 0; m_k = 1; m_svc = 0;
    end else begin
      int full, nc, ns, setv;
      bit open;
      full = m_pre << S;
      open = (m_cnt <= (full >> m_k));
      setv = 0; nc = m_cnt; ns = m_svc;
      if (!m_run) nc = full;
      else if (tick_en) begin
        if (m_cnt == 0) begin setv = 1; nc = full; end
        else nc = m_cnt - 1;
      end
      if (bus_we && bus_addr == 8'h0C) begin
        if (bus_wdata == 32'hE51A) ns = 1;
        else if (bus_wdata == 32'hA35C && m_svc == 1) begin
          ns = 0;
          if (m_run == 1) begin nc = full; if (!open) setv = 1; end
        end else ns = 0;
      end
      if (bus_we && bus_addr == 8'h08 && bus_wdata[1]) m_viol = 0;
      if (setv == 1) m_viol = 1;
      if (bus_we && bus_addr == 8'h00 && bus_wdata == 32'hA98559DA) m_run = 1;
      if (bus_we && bus_addr == 8'h04) m_pre = int'(bus_wdata[PW-1:0]);
      if (bus_we && bus_addr == 8'h14) begin
        if (bus_wdata == 32'hA) m_nmi = 1;
        else if (bus_wdata == 32'h5) m_nmi = 0;
      end
      if (bus_we && bus_addr == 8'h18) begin
        case (bus_wdata)
          32'h50:     m_k = 1;
          32'h500:    m_k = 2;
          32'h5000:   m_k = 3;
          32'h50000:  m_k = 4;
          32'h500000: m_k = 5;
          default: ;
        endcase
      end
      m_cnt = nc; m_svc = ns;
    end
  end

  function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
    case (a)
      8'h00: return (m_run == 1) ? 32'hA98559DA : 32'h0;
      8'h04: return 32'(m_pre);
      8'h08: return (m_viol == 1) ? 32'h2 : 32'h0;
      8'h10: return (m_viol == 1) ? 32'h0 : 32'(m_cnt);
      8'h14: return (m_nmi == 1) ? 32'hA : 32'h5;
      8'h18: return 32'h5 << (4 * m_k);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s at addr %h: actual %h expected %h", cur_tag, what, bus_addr, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("rdata", bus_rdata, exp_rd(bus_addr));
      chk("irq_o", 32'(irq_o), 32'(m_viol == 1 && m_nmi == 1));
      chk("rst_req_o", 32'(rst_req_o), 32'(m_viol == 1 && m_nmi == 0));
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    step(); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step(); bus_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a);
    step(); bus_addr = a; step();
  endtask

  task automatic wait_cnt(int lim);
    while (!(m_cnt <= lim && m_viol == 0)) step();
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cur_tag = "R3";  rd(8'h04); rd(8'h10);
    cur_tag = "R1";  rd(8'h00);
    cur_tag = "R9";  rd(8'h14);
    cur_tag = "R8";  rd(8'h18);
    cur_tag = "R10"; rd(8'h08);
    cur_tag = "R5";  rd(8'h0C); rd(8'h3C);

    cur_tag = "R1";  wr(8'h00, 32'hA98559DB); rd(8'h00);
    cur_tag = "R3";  wr(8'h04, 32'hFFFFF00A); rd(8'h10); rd(8'h04);
    cur_tag = "R8";  wr(8'h18, 32'h500); wr(8'h18, 32'h123); rd(8'h18);
    cur_tag = "R1";  wr(8'h00, 32'hA98559DA); rd(8'h00);

    cur_tag = "R4";  tick_en = 1'b1; bus_addr = 8'h10; repeat (5) step();
    tick_en = 1'b0; repeat (3) step(); tick_en = 1'b1;

    cur_tag = "R6";  wr(8'h0C, 32'hE51A); wr(8'h0C, 32'hA35C); rd(8'h08); rd(8'h10);
    cur_tag = "R10"; wr(8'h08, 32'h1); rd(8'h08); wr(8'h08, 32'h2); rd(8'h08);

    cur_tag = "R5";  wait_cnt(8); wr(8'h0C, 32'hE51A); wr(8'h0C, 32'hA35C);
    bus_addr = 8'h10; repeat (4) step(); rd(8'h08);

    cur_tag = "R7";  wait_cnt(8); wr(8'h0C, 32'hA35C); rd(8'h10);
    wr(8'h0C, 32'hE51A); wr(8'h0C, 32'h1234); wr(8'h0C, 32'hA35C); rd(8'h10);
    cur_tag = "R4";  bus_addr = 8'h10; while (m_viol == 0) step(); rd(8'h10); rd(8'h08);

    cur_tag = "R9";  wr(8'h14, 32'h7); rd(8'h14); wr(8'h14, 32'hA); rd(8'h14); rd(8'h08);
    cur_tag = "R2";  wr(8'h00, 32'h0); wr(8'h00, 32'hFFFFFFFF); rd(8'h00);

    cur_tag = "R11"; wr(8'h08, 32'h2); bus_addr = 8'h08; while (m_viol == 0) step(); rd(8'h08);
    cur_tag = "R10"; wr(8'h08, 32'h2);
    while (!(m_cnt == 0 && m_viol == 0)) step();
    wr(8'h08, 32'h2); rd(8'h08);

    cur_tag = "R8";  wr(8'h08, 32'h2); wr(8'h18, 32'h500000); rd(8'h18);
    wait_cnt(5); wr(8'h0C, 32'hE51A); wr(8'h0C, 32'hA35C); rd(8'h08);
    wr(8'h08, 32'h2); wr(8'h18, 32'h5000); wait_cnt(4);
    wr(8'h0C, 32'hE51A); wr(8'h0C, 32'hA35C); rd(8'h08);

    cur_tag = "R11"; wr(8'h14, 32'h5); rd(8'h08);
    cur_tag = "R3";  wr(8'h04, 32'h3); bus_addr = 8'h10; repeat (30) step();
    finish_run();
  end
endmodule